// File: doc/BRIEF.md
# Single-Precision Floating-Point Load/Store Format Converter

This block sits in the load/store path of a floating-point unit whose register file holds double-precision values while memory may hold single-precision words. A store request carries a 64-bit register value that the block narrows into a 32-bit memory word. A load request carries a 32-bit memory word that the block widens into a 64-bit register value. Each request is accepted with a one-cycle valid strobe, and exactly one registered response comes back on the following cycle.

Some operands are not converted in hardware. These are single-precision denormals on a load, and on a store any nonzero magnitude too small to be a normal single value. For these the block raises a trap flag instead of a result, so that a software assist routine can finish the operation. The data output is zero on a trap, so nothing meaningful is written. Rounding is plain truncation, and no status flags are kept.

Top module: `fp_ldst_conv`

## Requirements
- R1: A store of a normal double whose biased exponent lies in 897..1150 returns the original sign, the exponent minus 896 in bits 30:23, and the top 23 fraction bits (input bits 51:29) in bits 22:0.
- R2: A store of +0 or -0 returns a valid 32-bit zero that keeps the input sign in bit 31.
- R3: A store whose biased exponent lies in 874..896, which is the magnitude range of single denormals, raises the trap with rsp_data equal to zero.
- R4: A store of a normal double whose biased exponent lies in 1..873 is treated like a single denormal and raises the trap.
- R5: A store of a double denormal (exponent 0, fraction nonzero) raises the trap.
- R6: A store with exponent 2047 (infinity or NaN) returns exponent field 255, the input sign, and input fraction bits 51:29.
- R7: A store of a finite double whose exponent lies in 1151..2046 is too large for single format and returns a signed infinity (exponent 255, fraction 0).
- R8: A load of a normal single (exponent 1..254) returns the sign, the exponent plus 896 in bits 62:52, the 23 fraction bits in 51:29, and zeros in bits 28:0.
- R9: A load of a single zero returns a 64-bit zero that keeps the sign in bit 63.
- R10: A load of a single denormal (exponent field 0, fraction nonzero) raises the trap with rsp_data equal to zero.
- R11: A load with single exponent 255 returns exponent 2047, with the sign and fraction carried as in R8.
- R12: Each request with req_valid high produces exactly one of rsp_valid or rsp_trap on the next cycle. With no request, both are low and rsp_data is zero. Reset clears all outputs.
- R13: req_dir=1 selects store and req_dir=0 selects load. A load reads only req_data[31:0], and bits 63:32 have no effect. A store result sits in rsp_data[31:0] with bits 63:32 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_dir | input | 1 | 1 = store (narrow), 0 = load (widen) |
| req_data | input | 64 | Operand: a double for store, a single in bits 31:0 for load |
| rsp_valid | output | 1 | Converted result present |
| rsp_trap | output | 1 | Operand needs software assist, no result |
| rsp_data | output | 64 | Converted result, zero on trap or idle |

## Verification
Every result and every trap is due one clock edge after the cycle in which the request is presented, because only the output register lies between input and port. The bench drives each request on a falling edge and samples the outputs on the next falling edge, which falls half a period after the capturing edge. It then checks that the following idle cycle shows no response. The expected words come from bench functions written from the requirement text. Random operands are steered into each exponent band, and the band edges (873/874, 896/897, 1150/1151, 2046/2047) are driven directly.

// File: rtl/fp_conv_pkg.sv
package fp_conv_pkg;

  // Operand class shared by both conversion directions
  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } fp_class_e;

  // Default IEEE formats
  localparam int WIDE_EXP_W   = 11;
  localparam int WIDE_FRAC_W  = 52;
  localparam int NARROW_EXP_W = 8;
  localparam int NARROW_FRAC_W = 23;

  // Direction encoding on the request
  localparam logic DIR_LOAD  = 1'b0;
  localparam logic DIR_STORE = 1'b1;

endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fp_conv_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output fp_class_e         cls_o
);

  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

  logic exp_zero;
  logic exp_full;
  logic frac_zero;

  assign exp_zero  = (exp_i == '0);
  assign exp_full  = (exp_i == EXP_ALL1);
  assign frac_zero = (frac_i == '0);

  always_comb begin
    if (exp_zero && frac_zero)      cls_o = CLS_ZERO;
    else if (exp_zero)              cls_o = CLS_SUBNORM;
    else if (exp_full)              cls_o = CLS_SPECIAL;
    else                            cls_o = CLS_NORMAL;
  end

endmodule

// File: rtl/fp_narrow_store.sv
module fp_narrow_store
  import fp_conv_pkg::*;
#(
  parameter int WE = 11,
  parameter int WF = 52,
  parameter int NE = 8,
  parameter int NF = 23,
  localparam int WW = 1 + WE + WF,
  localparam int NW = 1 + NE + NF
) (
  input  logic [WW-1:0] wide_i,
  output logic [NW-1:0] narrow_o,
  output logic          trap_o
);

  localparam int WBIAS = (2 ** (WE - 1)) - 1;
  localparam int NBIAS = (2 ** (NE - 1)) - 1;
  localparam int BDIFF = WBIAS - NBIAS;
  // Range of wide exponents that map onto a normal narrow exponent
  localparam logic [WE-1:0] LO_E   = WE'(BDIFF + 1);
  localparam logic [WE-1:0] HI_E   = WE'(BDIFF + (2 ** NE) - 2);
  localparam logic [WE-1:0] BDIFF_E = WE'(BDIFF);
  localparam logic [NE-1:0] NEXP_ALL1 = '1;

  logic          sgn;
  logic [WE-1:0] wexp;
  logic [WF-1:0] wfrac;
  fp_class_e     cls;
  logic          too_small;
  logic          too_large;

  assign sgn   = wide_i[WW-1];
  assign wexp  = wide_i[WW-2 -: WE];
  assign wfrac = wide_i[WF-1:0];

  fp_classify #(.EXP_W(WE), .FRAC_W(WF)) u_cls (
    .exp_i  (wexp),
    .frac_i (wfrac),
    .cls_o  (cls)
  );

  assign too_small = (wexp < LO_E);
  assign too_large = (wexp > HI_E);

  always_comb begin
    narrow_o = '0;
    trap_o   = 1'b0;
    unique case (cls)
      CLS_ZERO: begin
        narrow_o = {sgn, {(NW-1){1'b0}}};
      end
      CLS_SUBNORM: begin
        trap_o = 1'b1;
      end
      CLS_SPECIAL: begin
        narrow_o = {sgn, NEXP_ALL1, wfrac[WF-1 -: NF]};
      end
      default: begin
        if (too_small) begin
          trap_o = 1'b1;
        end else if (too_large) begin
          narrow_o = {sgn, NEXP_ALL1, {NF{1'b0}}};
        end else begin
          narrow_o = {sgn, NE'(wexp - BDIFF_E), wfrac[WF-1 -: NF]};
        end
      end
    endcase
  end

endmodule

// File: rtl/fp_widen_load.sv
module fp_widen_load
  import fp_conv_pkg::*;
#(
  parameter int WE = 11,
  parameter int WF = 52,
  parameter int NE = 8,
  parameter int NF = 23,
  localparam int WW = 1 + WE + WF,
  localparam int NW = 1 + NE + NF
) (
  input  logic [NW-1:0] narrow_i,
  output logic [WW-1:0] wide_o,
  output logic          trap_o
);

  localparam int WBIAS = (2 ** (WE - 1)) - 1;
  localparam int NBIAS = (2 ** (NE - 1)) - 1;
  localparam logic [WE-1:0] BDIFF_E  = WE'(WBIAS - NBIAS);
  localparam logic [WE-1:0] WEXP_ALL1 = '1;
  localparam int PAD_W = WF - NF;

  logic          sgn;
  logic [NE-1:0] nexp;
  logic [NF-1:0] nfrac;
  fp_class_e     cls;

  assign sgn   = narrow_i[NW-1];
  assign nexp  = narrow_i[NW-2 -: NE];
  assign nfrac = narrow_i[NF-1:0];

  fp_classify #(.EXP_W(NE), .FRAC_W(NF)) u_cls (
    .exp_i  (nexp),
    .frac_i (nfrac),
    .cls_o  (cls)
  );

  always_comb begin
    wide_o = '0;
    trap_o = 1'b0;
    unique case (cls)
      CLS_ZERO:    wide_o = {sgn, {(WW-1){1'b0}}};
      CLS_SUBNORM: trap_o = 1'b1;
      CLS_SPECIAL: wide_o = {sgn, WEXP_ALL1, nfrac, {PAD_W{1'b0}}};
      default:     wide_o = {sgn, WE'(nexp) + BDIFF_E, nfrac, {PAD_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/fp_ldst_conv.sv
module fp_ldst_conv
  import fp_conv_pkg::*;
#(
  parameter int WE = WIDE_EXP_W,
  parameter int WF = WIDE_FRAC_W,
  parameter int NE = NARROW_EXP_W,
  parameter int NF = NARROW_FRAC_W,
  localparam int WW = 1 + WE + WF,
  localparam int NW = 1 + NE + NF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_dir,
  input  logic [WW-1:0] req_data,
  output logic          rsp_valid,
  output logic          rsp_trap,
  output logic [WW-1:0] rsp_data
);

  logic [NW-1:0] st_word;
  logic          st_trap;
  logic [WW-1:0] ld_word;
  logic          ld_trap;
  logic [WW-1:0] nxt_data;
  logic          nxt_trap;

  fp_narrow_store #(.WE(WE), .WF(WF), .NE(NE), .NF(NF)) u_store (
    .wide_i   (req_data),
    .narrow_o (st_word),
    .trap_o   (st_trap)
  );

  fp_widen_load #(.WE(WE), .WF(WF), .NE(NE), .NF(NF)) u_load (
    .narrow_i (req_data[NW-1:0]),
    .wide_o   (ld_word),
    .trap_o   (ld_trap)
  );

  always_comb begin
    if (req_dir == DIR_STORE) begin
      nxt_trap = st_trap;
      nxt_data = {{(WW-NW){1'b0}}, st_word};
    end else begin
      nxt_trap = ld_trap;
      nxt_data = ld_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !nxt_trap;
      rsp_trap  <= req_valid && nxt_trap;
      rsp_data  <= (req_valid && !nxt_trap) ? nxt_data : '0;
    end
  end

  // R12
  one_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_trap));

  // R12
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rsp_valid || rsp_trap) == $past(req_valid)));

  // R3
  trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_data == '0));

  // R2
  store_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_dir && (req_data[WW-2:0] == '0)))
      |-> (rsp_valid && rsp_data[NW-1] == $past(req_data[WW-1])
           && rsp_data[NW-2:0] == '0));

  // R13
  store_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && $past(req_dir)) |-> (rsp_data[WW-1:NW] == '0));

  // R8
  load_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && !$past(req_dir)) |-> (rsp_data[WF-NF-1:0] == '0));

  // R10
  load_denorm_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_dir && (req_data[NW-2 -: NE] == '0)
                          && (req_data[NF-1:0] != '0))) |-> rsp_trap);

  // R6
  store_special_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_dir && (&req_data[WW-2 -: WE])))
      |-> (rsp_valid && (&rsp_data[NW-2 -: NE])));

endmodule

// File: tb/test_fp_ldst_conv.sv
module test_fp_ldst_conv;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_dir = 1'b0;
  logic [63:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_trap;
  logic [63:0] rsp_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_ldst_conv i_fp_ldst_conv (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_dir   (req_dir),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_trap  (rsp_trap),
    .rsp_data  (rsp_data)
  );

  // Expected store result: {trap, 64-bit data}
  function automatic logic [64:0] exp_store(input logic [63:0] x);
    logic        s;
    logic [10:0] e;
    logic [51:0] f;
    s = x[63]; e = x[62:52]; f = x[51:0];
    if (e == 0 && f == 0) return {1'b0, 32'd0, s, 31'd0};          // R2
    if (e == 0)           return {1'b1, 64'd0};                     // R5
    if (e == 11'd2047)    return {1'b0, 32'd0, s, 8'hFF, f[51:29]}; // R6
    if (e > 11'd1150)     return {1'b0, 32'd0, s, 8'hFF, 23'd0};    // R7
    if (e < 11'd897)      return {1'b1, 64'd0};                     // R3 R4
    return {1'b0, 32'd0, s, 8'(e - 11'd896), f[51:29]};             // R1
  endfunction

  function automatic logic [64:0] exp_load(input logic [31:0] x);
    logic        s;
    logic [7:0]  e;
    logic [22:0] f;
    s = x[31]; e = x[30:23]; f = x[22:0];
    if (e == 0 && f == 0) return {1'b0, s, 63'd0};                      // R9
    if (e == 0)           return {1'b1, 64'd0};                         // R10
    if (e == 8'hFF)       return {1'b0, s, 11'h7FF, f, 29'd0};          // R11
    return {1'b0, s, 11'({3'd0, e} + 11'd896), f, 29'd0};               // R8
  endfunction

  function automatic string req_of_store(input logic [63:0] x);
    logic [10:0] e;
    e = x[62:52];
    if (e == 0) return (x[51:0] == 0) ? "R2" : "R5";
    if (e == 11'd2047) return "R6";
    if (e > 11'd1150) return "R7";
    if (e >= 11'd897) return "R1";
    if (e >= 11'd874) return "R3";
    return "R4";
  endfunction

  function automatic string req_of_load(input logic [31:0] x);
    if (x[30:23] == 0) return (x[22:0] == 0) ? "R9" : "R10";
    if (x[30:23] == 8'hFF) return "R11";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual trap=%0b data=%h expected trap=%0b data=%h",
               req, act[64], act[63:0], expv[64], expv[63:0]);
    end
  endtask

  // R12: one request, response sampled one edge later, then an idle cycle
  task automatic issue(input logic dir, input logic [63:0] d);
    logic [64:0] expv;
    string       req;
    if (dir) begin expv = exp_store(d); req = req_of_store(d); end
    else     begin expv = exp_load(d[31:0]); req = req_of_load(d[31:0]); end
    req_valid = 1'b1; req_dir = dir; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_data = ~d;
    check({req, "/R12 valid"}, {63'd0, rsp_valid, rsp_trap}, {63'd0, !expv[64], expv[64]});
    check(req, {rsp_trap, rsp_data}, expv);
    @(negedge clk);
    check("R12 idle", {rsp_valid, rsp_trap, rsp_data}, {2'b00, 64'd0});
  endtask

  function automatic logic [63:0] rnd_store(input int band);
    logic [10:0] e;
    logic [51:0] f;
    f = {20'($urandom), $urandom};
    unique case (band)
      0: begin e = 0; f = 0; end
      1: begin e = 0; if (f == 0) f = 52'd1; end
      2: e = 11'($urandom_range(1, 873));
      3: e = 11'($urandom_range(874, 896));
      4: e = 11'($urandom_range(897, 1150));
      5: e = 11'($urandom_range(1151, 2046));
      default: e = 11'd2047;
    endcase
    return {1'($urandom), e, f};
  endfunction

  function automatic logic [63:0] rnd_load(input int band);
    logic [7:0]  e;
    logic [22:0] f;
    f = 23'($urandom);
    unique case (band)
      0: begin e = 0; f = 0; end
      1: begin e = 0; if (f == 0) f = 23'd1; end
      2: e = 8'hFF;
      default: e = 8'($urandom_range(1, 254));
    endcase
    // R13: random upper half must not matter
    return {$urandom, 1'($urandom), e, f};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {rsp_valid, rsp_trap, rsp_data}, {2'b00, 64'd0});
    rst = 1'b0;
    @(negedge clk);
    check("R12 idle after reset", {rsp_valid, rsp_trap, rsp_data}, {2'b00, 64'd0});

    // Directed store corners
    issue(1'b1, 64'h0000_0000_0000_0000);                 // R2 +0
    issue(1'b1, 64'h8000_0000_0000_0000);                 // R2 -0
    issue(1'b1, 64'h0000_0000_0000_0001);                 // R5
    issue(1'b1, {1'b0, 11'd1, 52'h1});                    // R4 low end
    issue(1'b1, {1'b1, 11'd873, 52'hF_FFFF_FFFF_FFFF});   // R4 upper edge
    issue(1'b1, {1'b0, 11'd874, 52'd0});                  // R3 lower edge
    issue(1'b1, {1'b1, 11'd896, 52'hF_FFFF_FFFF_FFFF});   // R3 upper edge
    issue(1'b1, {1'b0, 11'd897, 52'd0});                  // R1 smallest normal
    issue(1'b1, {1'b1, 11'd1150, 52'hF_FFFF_FFFF_FFFF});  // R1 largest normal
    issue(1'b1, {1'b0, 11'd1151, 52'd0});                 // R7
    issue(1'b1, {1'b1, 11'd2046, 52'h1});                 // R7
    issue(1'b1, {1'b0, 11'd2047, 52'd0});                 // R6 infinity
    issue(1'b1, {1'b1, 11'd2047, 52'h8_0000_0000_0000});  // R6 NaN
    issue(1'b1, 64'h3FF0_0000_0000_0000);                 // R1 one
    // Directed load corners
    issue(1'b0, 64'hFFFF_FFFF_0000_0000);                 // R9 +0, R13 upper ignored
    issue(1'b0, 64'h0000_0000_8000_0000);                 // R9 -0
    issue(1'b0, 64'h0000_0000_0000_0001);                 // R10
    issue(1'b0, 64'hFFFF_FFFF_807F_FFFF);                 // R10
    issue(1'b0, 64'h0000_0000_0080_0000);                 // R8 smallest normal
    issue(1'b0, 64'h0000_0000_FF7F_FFFF);                 // R8 largest normal
    issue(1'b0, 64'h1234_5678_7F80_0000);                 // R11 infinity
    issue(1'b0, 64'h0000_0000_FFC0_0001);                 // R11 NaN
    issue(1'b0, 64'h0000_0000_3F80_0000);                 // R8 one

    // Random mix
    for (int i = 0; i < 700; i++) begin
      if ($urandom_range(0, 1) == 1) issue(1'b1, rnd_store(int'($urandom_range(0, 6))));
      else                           issue(1'b0, rnd_load(int'($urandom_range(0, 3))));
    end

    // R12 back-to-back: store then load in consecutive cycles
    req_valid = 1'b1; req_dir = 1'b1; req_data = 64'h4000_0000_0000_0000;
    @(negedge clk);
    check("R1 back-to-back", {rsp_trap, rsp_data}, exp_store(64'h4000_0000_0000_0000));
    req_dir = 1'b0; req_data = 64'h0000_0000_0000_0005;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 back-to-back", {rsp_trap, rsp_data}, exp_load(32'h0000_0005));
    check("R12 back-to-back", {63'd0, rsp_valid, rsp_trap}, {63'd0, 2'b01});
    @(negedge clk);
    check("R12 idle end", {rsp_valid, rsp_trap, rsp_data}, {2'b00, 64'd0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule